// File: doc/BRIEF.md
# Carry-Partitioned Packed Adder

This block adds two 32-bit words whose carry chain can be cut at any bit position. A 32-bit partition mask, held in a register inside the block, selects the cut points. Each set mask bit stops the carry from entering that bit, and that bit becomes the least significant bit of a new packed field. The word therefore acts as a set of independent fields of any widths, such as the uneven 5/6/5 colour channels of two packed 16-bit pixels. Each field wraps modulo two to the power of its own width.

Software loads the mask through a write-enable port. An operation uses the mask value that is registered at the time the operation is issued. A valid strobe qualifies each operation, and the sum is returned through an output register one cycle later.

Top module: `part_adder`

## Requirements
- R1: After the asynchronous reset (rst_ni low), valid_o is 0, sum_o is 0 and the partition mask register is all zeros.
- R2: valid_o is 1 in the cycle after a cycle with in_valid_i high, and 0 in the cycle after a cycle with in_valid_i low.
- R3: With an all-zero mask, sum_o equals (a_i + b_i) modulo 2^32, and the carry out of bit 31 is dropped.
- R4: For any mask, a set bit i (i ≥ 1) forces the carry into bit i to zero. Each field runs from one set bit, or from bit 0, up to the bit below the next set bit, or up to bit 31. Each field's result is the sum of the two operand fields modulo 2^width, and its carry out is discarded.
- R5: With mask bits 5, 11, 16, 21 and 27 set, the fields 4..0, 10..5, 15..11, 20..16, 26..21 and 31..27 are summed independently.
- R6: Mask bit 0 has no effect on the result.
- R7: When mask_we_i is high at a clock edge, the mask register takes mask_i. An operation issued in the same cycle as the write uses the previous mask. Operations from the next cycle on use the new mask.
- R8: sum_o holds its value in every cycle that follows a cycle with in_valid_i low.
- R9: With an all-ones mask, every bit of sum_o is the XOR of the matching operand bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Write enable for the partition mask register |
| mask_i | input | 32 | New partition mask value |
| in_valid_i | input | 1 | Qualifies the operands |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sum_o | output | 32 | Registered packed sum |
| valid_o | output | 1 | Result valid, one cycle after in_valid_i |

## Verification
If the mask register holds a wrong value, the error shows up at the ports as misplaced field wraps in the very next result whose operands produce a carry across the affected bit. Random operands make such carries frequent, so the bench finds the fault within a few operations. A fault in the carry gating appears in the next valid result. The bench tests writes in the same cycle as an operation, and one cycle before it, to find an off-by-one in mask timing. It also compares sum_o on idle cycles to find a result register that reloads when it should hold.

// File: rtl/part_pkg.sv
package part_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/part_mask_reg.sv
module part_mask_reg #(
  parameter int unsigned W = part_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_mask_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  assert_mask_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/part_carry_chain.sv
module part_carry_chain #(
  parameter int unsigned W = part_pkg::WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] brk_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cy;   // raw carry into each bit
  logic [W-1:0] cin;  // carry after partition gating

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign cin[i]   = cy[i] & ~brk_i[i];
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cin[i];
    if (i < W - 1) begin : g_cy
      // carry out of the top bit is dropped
      assign cy[i+1] = (a_i[i] & b_i[i]) | (cin[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/part_result_reg.sv
module part_result_reg #(
  parameter int unsigned W = part_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) sum_o <= d_i;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && sum_o == $past(d_i));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !valid_o && $stable(sum_o));
endmodule

// File: rtl/part_adder.sv
module part_adder #(
  parameter int unsigned W = part_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         valid_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] sum_d;

  part_mask_reg #(.W(W)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mask_we_i),
    .d_i   (mask_i),
    .q_o   (mask_q)
  );

  part_carry_chain #(.W(W)) u_chain (
    .a_i  (a_i),
    .b_i  (b_i),
    .brk_i(mask_q),
    .sum_o(sum_d)
  );

  part_result_reg #(.W(W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i),
    .d_i    (sum_d),
    .sum_o  (sum_o),
    .valid_o(valid_o)
  );

  assert_plain_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_q == '0) |=> sum_o == $past(a_i + b_i));
  assert_no_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_q == '1) |=> sum_o == $past(a_i ^ b_i));
  assert_msb_field_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_q[W-1]) |=> sum_o[W-1] == $past(a_i[W-1] ^ b_i[W-1]));
endmodule

// File: tb/part_adder_tb.sv
`timescale 1ns/1ps
module part_adder_tb;
  localparam int W = 32;
  localparam logic [W-1:0] RGB_MASK = 32'h0821_0820; // bits 5,11,16,21,27

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mask_we = 1'b0;
  logic [W-1:0] mask_in = '0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum_o;
  logic         valid_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  part_adder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mask_we_i(mask_we), .mask_i(mask_in),
    .in_valid_i(in_valid), .a_i(a), .b_i(b), .sum_o(sum_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int lo = 0;
    for (int i = 1; i <= W; i++) begin
      if (i == W || m[i]) begin
        longint unsigned fm = (64'd1 << (i - lo)) - 1;
        longint unsigned fs = (((longint'(x) >> lo) & fm) + ((longint'(y) >> lo) & fm)) & fm;
        r = r | W'(fs << lo);
        lo = i;
      end
    end
    return r;
  endfunction

  // behavioural reference: mask register, output register
  logic [W-1:0] m_mask, m_sum;
  logic         m_valid;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= '0; m_sum <= '0; m_valid <= 1'b0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) m_sum <= ref_sum(a, b, m_mask);
      if (mask_we) m_mask <= mask_in;
    end
  end

  task automatic check();
    n_chk++;
    if (valid_o !== m_valid) begin
      n_fail++;
      $display("FAIL %s/R2 valid_o actual=%0b expected=%0b", cur_req, valid_o, m_valid);
    end else if (sum_o !== m_sum) begin
      n_fail++;
      $display("FAIL %s sum_o actual=%h expected=%h", cur_req, sum_o, m_sum);
    end
  endtask

  task automatic step(input logic we, input logic [W-1:0] m, input logic v,
                      input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    check();
    mask_we = we; mask_in = m; in_valid = v; a = x; b = y;
  endtask

  task automatic set_mask(input logic [W-1:0] m);
    step(1'b1, m, 1'b0, '0, '0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    step(0, '0, 0, '0, '0);
    step(0, '0, 0, '0, '0);
    // reset mask is zero: plain add right after reset
    step(0, '0, 1, 32'h0000_FFFF, 32'h0000_0001);

    cur_req = "R3";
    step(0, '0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    step(0, '0, 1, 32'h8000_0000, 32'h8000_0000);
    for (int i = 0; i < 20; i++) step(0, '0, 1, $urandom, $urandom);

    cur_req = "R5";
    set_mask(RGB_MASK);
    step(0, '0, 1, 32'hFFFF_FFFF, 32'h0001_0001);
    step(0, '0, 1, 32'h07E0_F81F, 32'h0821_0821);
    for (int i = 0; i < 30; i++) step(0, '0, 1, $urandom, $urandom);

    cur_req = "R6";
    set_mask(32'h0000_0001);
    step(0, '0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    step(0, '0, 1, 32'h0000_0001, 32'h0000_0001);
    set_mask(RGB_MASK | 32'h1);
    step(0, '0, 1, 32'h0000_001F, 32'h0000_0001);

    cur_req = "R9";
    set_mask('1);
    step(0, '0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) step(0, '0, 1, $urandom, $urandom);

    cur_req = "R4";
    for (int i = 0; i < 200; i++) begin
      step(i % 3 == 0, $urandom & $urandom, 1, $urandom, $urandom);
    end
    for (int i = 1; i < W; i++) begin
      set_mask(32'h1 << i);
      step(0, '0, 1, 32'hFFFF_FFFF, 32'h0000_0001);
    end

    cur_req = "R7";
    set_mask('0);
    // write and operate in the same cycle: old (zero) mask applies
    step(1, 32'h0000_0100, 1, 32'h0000_00FF, 32'h0000_0001);
    // next cycle sees the new mask
    step(0, '0, 1, 32'h0000_00FF, 32'h0000_0001);
    step(1, 32'h0000_0000, 1, 32'h0000_00FF, 32'h0000_0001);
    step(0, '0, 1, 32'h0000_00FF, 32'h0000_0001);

    cur_req = "R8";
    step(0, '0, 1, 32'h1234_5678, 32'h1111_1111);
    for (int i = 0; i < 8; i++) step(0, '0, 0, $urandom, $urandom);
    step(1, 32'hFFFF_0000, 0, $urandom, $urandom);
    step(0, '0, 0, '0, '0);
    step(0, '0, 0, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule